// File: doc/BRIEF.md
# Barker Peak-Valley Spread-Spectrum Packet Detector

This block decides whether a direct-sequence spread-spectrum packet is arriving, using real-valued baseband samples taken at one sample per chip. A matched filter correlates the last eleven valid samples with the 11-chip Barker code. The correlation magnitudes are cut into symbol-length windows. Each window yields its strongest magnitude, where in the window that magnitude sits, and the total of its other magnitudes (the "valley").

A real preamble puts its correlation peak at the same place in every window. The detector counts consecutive windows whose peak positions agree to within one sample. When that count reaches a programmable length, it compares the run's summed peaks, scaled up by a programmable shift, against the run's summed valleys. A pass is a spread-spectrum detection.

The detection result is merged with a detection pulse from a parallel multicarrier detector into a latched one-hot mode flag. The multicarrier result wins a same-cycle tie because its preamble is far shorter. Once set, the flag holds until it is cleared.

Top module: `dsss_packet_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, all state clears and `mode_flag` reads 2'b00.
- R2: Each valid sample produces a correlation magnitude equal to the absolute value of the sum, over the last eleven valid samples, of each sample multiplied by the chip of the code +1 +1 +1 -1 -1 -1 +1 -1 -1 +1 -1. The oldest of the eleven samples meets the first chip. Positions before the first valid sample since reset count as zero, and the sign of the data bit does not matter.
- R3: Magnitudes are grouped into consecutive windows of WIN (default 11), starting from the first valid sample after reset. Each window reports three values:
  - its largest magnitude;
  - the position of that magnitude, 0 to WIN-1, taking the earliest position on a tie;
  - the sum of the window's other magnitudes.
- R4: A window extends the current run when its peak position differs from the previous window's peak position by at most one.
- R5: A window whose peak position differs by more than one restarts the run, with that window as the run's first window.
- R6: When a run reaches `cfg_need` windows, the energy test is evaluated and the run is emptied whatever the result. A `cfg_need` of 0 is treated as 1.
- R7: The energy test passes when (sum of the run's peaks) shifted left by `cfg_shift` is strictly greater than the sum of the run's valleys. Equality fails.
- R8: `mode_flag` is one-hot or zero: bit 1 means multicarrier and bit 0 means spread-spectrum. From 2'b00 it latches on the first detection. It then holds against all later detections until `mode_clr`.
- R9: When `ofdm_det` and a spread-spectrum decision arrive in the same cycle while the flag is 2'b00, the flag becomes 2'b10.
- R10: `mode_clr` makes `mode_flag` 2'b00 at the next edge. This takes priority over any detection in the same cycle, and that detection is lost.
- R11: A sample presented with `samp_vld` low has no effect on any later output.
- R12: A passing test changes `mode_flag` at the third rising edge after the edge that captures the last sample of the window that completed the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_vld | input | 1 | Sample strobe, one per chip |
| samp_in | input | SAMP_W | Signed real baseband sample |
| cfg_need | input | NEED_W | Number of aligned windows in a run |
| cfg_shift | input | SHIFT_W | Left shift applied to the peak sum |
| ofdm_det | input | 1 | Detection pulse from the multicarrier detector |
| mode_clr | input | 1 | Clears the latched mode flag |
| mode_flag | output | 2 | Latched one-hot mode: bit 1 multicarrier, bit 0 spread-spectrum |

## Verification
The in-line assertions check on every cycle the flag-level rules:
- one-hot encoding;
- holding once latched;
- clear priority;
- the multicarrier tie-break;
- latching of a spread-spectrum decision;
- bounds on the window counter and on the run state.

Whether the peak-position tracking, run restarts and energy comparison reach the right decision can only be shown by the bench's scenarios. These are:
- clean and alternating-data Barker streams;
- streams broken by one-sample and two-sample slips;
- constant inputs that sit on either side of the energy threshold;
- strobes with idle gaps.

The bench's per-cycle reference model also confirms the three-edge decision latency.

// File: rtl/dsss_det_pkg.sv
// Shared constants and types for the spread-spectrum packet detector.
// Assumes an 11-chip Barker code; bit i of BARKER_CHIPS is chip i (1 = +1).
package dsss_det_pkg;
    localparam int BARKER_LEN = 11;
    localparam logic [BARKER_LEN-1:0] BARKER_CHIPS = 11'b01001000111;
    localparam int MODE_DSSS_BIT = 0;
    localparam int MODE_OFDM_BIT = 1;
    typedef enum logic {TRK_IDLE, TRK_RUN} trk_state_t;
endpackage

// File: rtl/dsss_barker_corr.sv
// Matched filter: correlates the newest eleven valid samples with the Barker
// code and registers the magnitude. Assumes samples arrive one per chip.
module dsss_barker_corr
    import dsss_det_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int MAG_W  = SAMP_W + $clog2(BARKER_LEN) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic signed [SAMP_W-1:0] in_samp,
    output logic                     mag_vld,
    output logic [MAG_W-1:0]         mag
);
    logic signed [SAMP_W-1:0] taps_q [BARKER_LEN-1];
    logic signed [SAMP_W-1:0] line_c [BARKER_LEN];
    logic signed [MAG_W-1:0]  acc_c;
    logic signed [MAG_W-1:0]  abs_c;

    // Build the tap line with the incoming sample and sum signed products.
    always_comb begin
        line_c[0] = in_samp;
        for (int k = 1; k < BARKER_LEN; k++) line_c[k] = taps_q[k-1];
        acc_c = '0;
        for (int k = 0; k < BARKER_LEN; k++) begin
            if (BARKER_CHIPS[BARKER_LEN-1-k]) acc_c = acc_c + MAG_W'(line_c[k]);
            else                              acc_c = acc_c - MAG_W'(line_c[k]);
        end
        abs_c = acc_c[MAG_W-1] ? -acc_c : acc_c;
    end

    // Shift valid samples in and register the magnitude with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < BARKER_LEN-1; k++) taps_q[k] <= '0;
            mag_vld <= 1'b0;
            mag     <= '0;
        end else begin
            mag_vld <= in_vld;
            if (in_vld) begin
                for (int k = 0; k < BARKER_LEN-1; k++) taps_q[k] <= line_c[k];
                mag <= abs_c;
            end
        end
    end
endmodule

// File: rtl/dsss_window_peak.sv
// Splits the magnitude stream into windows of WIN values and reports, per
// window, the peak (earliest on ties), its position and the valley energy.
module dsss_window_peak #(
    parameter int WIN   = 11,
    parameter int MAG_W = 13,
    parameter int POS_W = $clog2(WIN),
    parameter int VAL_W = MAG_W + $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mag_vld,
    input  logic [MAG_W-1:0] mag,
    output logic             win_vld,
    output logic [MAG_W-1:0] win_peak,
    output logic [POS_W-1:0] win_pos,
    output logic [VAL_W-1:0] win_valley
);
    logic [POS_W-1:0] idx_q;
    logic [MAG_W-1:0] best_q, best_c;
    logic [POS_W-1:0] bpos_q, bpos_c;
    logic [VAL_W-1:0] total_q, total_c;
    logic             take_c;
    logic             last_c;

    // Candidate peak and running total including the current magnitude.
    always_comb begin
        take_c  = (idx_q == '0) || (mag > best_q);
        best_c  = take_c ? mag : best_q;
        bpos_c  = take_c ? idx_q : bpos_q;
        total_c = ((idx_q == '0) ? '0 : total_q) + VAL_W'(mag);
        last_c  = (int'(idx_q) == WIN - 1);
    end

    // Advance the window and publish its summary on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            best_q     <= '0;
            bpos_q     <= '0;
            total_q    <= '0;
            win_vld    <= 1'b0;
            win_peak   <= '0;
            win_pos    <= '0;
            win_valley <= '0;
        end else begin
            win_vld <= 1'b0;
            if (mag_vld) begin
                if (last_c) begin
                    idx_q      <= '0;
                    win_vld    <= 1'b1;
                    win_peak   <= best_c;
                    win_pos    <= bpos_c;
                    win_valley <= total_c - VAL_W'(best_c);
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    best_q  <= best_c;
                    bpos_q  <= bpos_c;
                    total_q <= total_c;
                end
            end
        end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx_q) < WIN); // R3
    AST_WIN_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_vld |-> $past(mag_vld)); // R3
endmodule

// File: rtl/dsss_run_tracker.sv
// Decision state machine: chains windows whose peak positions agree within
// one sample, accumulates peak and valley sums, and runs the energy test
// once the chain reaches the requested length. Assumes cfg is static
// outside reset.
module dsss_run_tracker
    import dsss_det_pkg::*;
#(
    parameter int MAG_W   = 13,
    parameter int POS_W   = 4,
    parameter int VAL_W   = 17,
    parameter int NEED_W  = 4,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NEED_W-1:0]  cfg_need,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic               win_vld,
    input  logic [MAG_W-1:0]   win_peak,
    input  logic [POS_W-1:0]   win_pos,
    input  logic [VAL_W-1:0]   win_valley,
    output logic               dsss_hit
);
    localparam int PSUM_W = MAG_W + NEED_W;
    localparam int VSUM_W = VAL_W + NEED_W;
    localparam int SHL_W  = PSUM_W + (2**SHIFT_W) - 1;
    localparam int CMP_W  = (SHL_W > VSUM_W) ? SHL_W : VSUM_W;

    trk_state_t        st_q;
    logic [POS_W-1:0]  prev_q;
    logic [NEED_W-1:0] run_q, run_c, need_c;
    logic [PSUM_W-1:0] psum_q, psum_c;
    logic [VSUM_W-1:0] vsum_q, vsum_c;
    logic [POS_W-1:0]  dist_c;
    logic              near_c, full_c, pass_c;
    logic [CMP_W-1:0]  shl_c;

    // Spacing check, run extension and the peak-over-valley comparison.
    always_comb begin
        need_c = (cfg_need == '0) ? NEED_W'(1) : cfg_need;
        dist_c = (win_pos >= prev_q) ? (win_pos - prev_q) : (prev_q - win_pos);
        near_c = (st_q == TRK_RUN) && (dist_c <= POS_W'(1));
        run_c  = near_c ? (run_q + 1'b1) : NEED_W'(1);
        psum_c = (near_c ? psum_q : '0) + PSUM_W'(win_peak);
        vsum_c = (near_c ? vsum_q : '0) + VSUM_W'(win_valley);
        full_c = (run_c >= need_c);
        shl_c  = CMP_W'(psum_c) << cfg_shift;
        pass_c = shl_c > CMP_W'(vsum_c);
    end

    // Update the run on each window summary; empty it after a decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= TRK_IDLE;
            prev_q   <= '0;
            run_q    <= '0;
            psum_q   <= '0;
            vsum_q   <= '0;
            dsss_hit <= 1'b0;
        end else begin
            dsss_hit <= 1'b0;
            if (win_vld) begin
                if (full_c) begin
                    st_q     <= TRK_IDLE;
                    run_q    <= '0;
                    psum_q   <= '0;
                    vsum_q   <= '0;
                    dsss_hit <= pass_c;
                end else begin
                    st_q   <= TRK_RUN;
                    prev_q <= win_pos;
                    run_q  <= run_c;
                    psum_q <= psum_c;
                    vsum_q <= vsum_c;
                end
            end
        end
    end

    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TRK_RUN) |-> (run_q != '0)); // R5
    AST_HIT_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        dsss_hit |-> $past(win_vld)); // R6
    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dsss_hit |=> !dsss_hit); // R6
endmodule

// File: rtl/dsss_packet_detector.sv
// Top level: matched filter, window peak finder, run tracker and the latched
// one-hot mode flag with multicarrier priority. Assumes one sample per chip.
module dsss_packet_detector
    import dsss_det_pkg::*;
#(
    parameter int SAMP_W  = 8,
    parameter int WIN     = BARKER_LEN,
    parameter int NEED_W  = 4,
    parameter int SHIFT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     samp_vld,
    input  logic signed [SAMP_W-1:0] samp_in,
    input  logic [NEED_W-1:0]        cfg_need,
    input  logic [SHIFT_W-1:0]       cfg_shift,
    input  logic                     ofdm_det,
    input  logic                     mode_clr,
    output logic [1:0]               mode_flag
);
    localparam int MAG_W = SAMP_W + $clog2(BARKER_LEN) + 1;
    localparam int POS_W = $clog2(WIN);
    localparam int VAL_W = MAG_W + $clog2(WIN);

    logic             mag_vld;
    logic [MAG_W-1:0] mag;
    logic             win_vld;
    logic [MAG_W-1:0] win_peak;
    logic [POS_W-1:0] win_pos;
    logic [VAL_W-1:0] win_valley;
    logic             dsss_hit;

    dsss_barker_corr #(.SAMP_W(SAMP_W), .MAG_W(MAG_W)) u_corr (
        .clk(clk), .rst_n(rst_n), .in_vld(samp_vld), .in_samp(samp_in),
        .mag_vld(mag_vld), .mag(mag)
    );

    dsss_window_peak #(.WIN(WIN), .MAG_W(MAG_W), .POS_W(POS_W), .VAL_W(VAL_W)) u_win (
        .clk(clk), .rst_n(rst_n), .mag_vld(mag_vld), .mag(mag),
        .win_vld(win_vld), .win_peak(win_peak), .win_pos(win_pos),
        .win_valley(win_valley)
    );

    dsss_run_tracker #(.MAG_W(MAG_W), .POS_W(POS_W), .VAL_W(VAL_W),
                       .NEED_W(NEED_W), .SHIFT_W(SHIFT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .cfg_need(cfg_need), .cfg_shift(cfg_shift),
        .win_vld(win_vld), .win_peak(win_peak), .win_pos(win_pos),
        .win_valley(win_valley), .dsss_hit(dsss_hit)
    );

    // Latch the first detection; clear wins, multicarrier wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_flag <= 2'b00;
        end else if (mode_clr) begin
            mode_flag <= 2'b00;
        end else if (mode_flag == 2'b00) begin
            if (ofdm_det)      mode_flag[MODE_OFDM_BIT] <= 1'b1;
            else if (dsss_hit) mode_flag[MODE_DSSS_BIT] <= 1'b1;
        end
    end

    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_flag)); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flag != 2'b00 && !mode_clr) |=> $stable(mode_flag)); // R8
    AST_DSSS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flag == 2'b00 && !mode_clr && !ofdm_det && dsss_hit) |=> mode_flag == 2'b01); // R8
    AST_OFDM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_flag == 2'b00 && !mode_clr && ofdm_det) |=> mode_flag == 2'b10); // R9
    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        mode_clr |=> mode_flag == 2'b00); // R10
endmodule

// File: tb/dsss_packet_detector_tb.sv
`timescale 1ns/1ps
module dsss_packet_detector_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              samp_vld = 1'b0;
    logic signed [7:0] samp_in = '0;
    logic [3:0]        cfg_need = 4'd4;
    logic [2:0]        cfg_shift = 3'd2;
    logic              ofdm_det = 1'b0;
    logic              mode_clr = 1'b0;
    logic [1:0]        mode_flag;

    int checks = 0;
    int errors = 0;
    int bk [11] = '{1, 1, 1, -1, -1, -1, 1, -1, -1, 1, -1};

    // Reference model state (behavioural, integer based).
    int m_hist [$];
    bit m_mag_vld, m_wv, m_trk, m_hit;
    int m_mag, m_idx, m_best, m_bpos, m_tot;
    int m_wpk, m_wpos, m_wval, m_prev, m_run, m_ps, m_vs;
    bit [1:0] m_mode;

    always #2 clk = ~clk;

    dsss_packet_detector u_dut (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .samp_in(samp_in),
        .cfg_need(cfg_need), .cfg_shift(cfg_shift), .ofdm_det(ofdm_det),
        .mode_clr(mode_clr), .mode_flag(mode_flag)
    );

    // Reference model, stages evaluated from the output backwards.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = {};
            m_mag_vld = 0; m_wv = 0; m_trk = 0; m_hit = 0; m_mode = 2'b00;
            m_mag = 0; m_idx = 0; m_best = 0; m_bpos = 0; m_tot = 0;
            m_wpk = 0; m_wpos = 0; m_wval = 0; m_prev = 0; m_run = 0; m_ps = 0; m_vs = 0;
        end else begin
            int need, run, ps, vs, c;
            bit near;
            if (mode_clr) m_mode = 2'b00;
            else if (m_mode == 2'b00) begin
                if (ofdm_det) m_mode = 2'b10;
                else if (m_hit) m_mode = 2'b01;
            end
            m_hit = 0;
            if (m_wv) begin
                need = (cfg_need == 0) ? 1 : int'(cfg_need);
                near = m_trk && ((m_wpos - m_prev <= 1) && (m_prev - m_wpos <= 1));
                run = near ? m_run + 1 : 1;
                ps = (near ? m_ps : 0) + m_wpk;
                vs = (near ? m_vs : 0) + m_wval;
                if (run >= need) begin
                    m_trk = 0; m_run = 0; m_ps = 0; m_vs = 0;
                    m_hit = ((longint'(ps) << cfg_shift) > longint'(vs));
                end else begin
                    m_trk = 1; m_prev = m_wpos; m_run = run; m_ps = ps; m_vs = vs;
                end
            end
            m_wv = 0;
            if (m_mag_vld) begin
                if (m_idx == 0 || m_mag > m_best) begin m_best = m_mag; m_bpos = m_idx; end
                m_tot = ((m_idx == 0) ? 0 : m_tot) + m_mag;
                if (m_idx == 10) begin
                    m_wv = 1; m_wpk = m_best; m_wpos = m_bpos; m_wval = m_tot - m_best; m_idx = 0;
                end else m_idx++;
            end
            m_mag_vld = samp_vld;
            if (samp_vld) begin
                m_hist.push_front(int'(samp_in));
                if (m_hist.size() > 11) void'(m_hist.pop_back());
                c = 0;
                for (int k = 0; k < m_hist.size(); k++) c += m_hist[k] * bk[10-k];
                m_mag = (c < 0) ? -c : c;
            end
        end
    end

    // Per-cycle comparison of the flag against the model (R12 timing).
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (mode_flag !== m_mode) begin
                errors++;
                $display("FAIL R12 cycle model: mode_flag=%b expected %b at %0t", mode_flag, m_mode, $time);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual hang expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: mode_flag=%b expected %b", req, act, exp);
        end
    endtask

    task automatic restart(input int need, input int sh);
        @(negedge clk);
        rst_n = 0; samp_vld = 0; ofdm_det = 0; mode_clr = 0;
        cfg_need = 4'(need); cfg_shift = 3'(sh);
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send(input int v);
        @(negedge clk);
        samp_vld = 1; samp_in = 8'(v);
    endtask

    task automatic send_sym(input int d, input int a);
        for (int j = 0; j < 11; j++) send(d * a * bk[j]);
    endtask

    task automatic zeros(input int n);
        for (int j = 0; j < n; j++) send(0);
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            samp_vld = 0; samp_in = -8'sd100;
        end
    endtask

    task automatic poke_on_hit(input bit do_ofdm, input bit do_clr);
        do @(negedge clk); while (!m_hit);
        ofdm_det = do_ofdm; mode_clr = do_clr;
        @(negedge clk);
        ofdm_det = 0; mode_clr = 0;
    endtask

    initial begin
        // R1: reset state
        restart(4, 2);
        @(negedge clk);
        chk("R1 reset", mode_flag, 2'b00);

        // R2 R3 R12: four clean symbols, decision latency
        restart(4, 2);
        for (int s = 0; s < 4; s++) send_sym(1, 20);
        idle(1);
        @(negedge clk);
        @(negedge clk);
        chk("R12 not before third edge", mode_flag, 2'b00);
        @(negedge clk);
        chk("R12 R3 latched at third edge", mode_flag, 2'b01);

        // R2: alternating data polarity after leading zeros
        restart(4, 2);
        zeros(4);
        for (int s = 0; s < 6; s++) send_sym((s % 2 == 0) ? 1 : -1, 20);
        idle(6);
        chk("R2 alternating data detects", mode_flag, 2'b01);

        // R6: run shorter than cfg_need gives nothing; need 0 acts as 1
        restart(6, 2);
        for (int s = 0; s < 5; s++) send_sym(1, 20);
        idle(6);
        chk("R6 five windows short of six", mode_flag, 2'b00);
        restart(0, 2);
        send_sym(1, 20);
        idle(6);
        chk("R6 need zero acts as one", mode_flag, 2'b01);

        // R4: one-sample slip keeps the run
        restart(6, 2);
        zeros(4);
        for (int s = 0; s < 4; s++) send_sym(1, 20);
        zeros(1);
        for (int s = 0; s < 4; s++) send_sym(1, 20);
        zeros(11);
        idle(6);
        chk("R4 one-sample slip tolerated", mode_flag, 2'b01);

        // R5: two-sample slip restarts the run
        restart(6, 2);
        zeros(4);
        for (int s = 0; s < 4; s++) send_sym(1, 20);
        zeros(2);
        for (int s = 0; s < 4; s++) send_sym(1, 20);
        zeros(11);
        idle(6);
        chk("R5 two-sample slip breaks run", mode_flag, 2'b00);

        // R7: constant input, peak ratio 1:10 against shift 3 and 4
        restart(4, 3);
        for (int j = 0; j < 66; j++) send(10);
        idle(6);
        chk("R7 shift 3 fails energy test", mode_flag, 2'b00);
        restart(4, 4);
        for (int j = 0; j < 66; j++) send(10);
        idle(6);
        chk("R7 shift 4 passes energy test", mode_flag, 2'b01);

        // R8: multicarrier alone, hold, clear, then spread-spectrum hold
        restart(4, 2);
        @(negedge clk); ofdm_det = 1;
        @(negedge clk); ofdm_det = 0;
        chk("R8 multicarrier encoding", mode_flag, 2'b10);
        for (int s = 0; s < 4; s++) send_sym(1, 20);
        idle(6);
        chk("R8 held against later detection", mode_flag, 2'b10);
        @(negedge clk); mode_clr = 1;
        @(negedge clk); mode_clr = 0;
        chk("R10 clear returns to idle", mode_flag, 2'b00);
        for (int s = 0; s < 4; s++) send_sym(-1, 20);
        idle(6);
        chk("R8 spread-spectrum latched", mode_flag, 2'b01);
        @(negedge clk); ofdm_det = 1;
        @(negedge clk); ofdm_det = 0;
        chk("R8 held against multicarrier", mode_flag, 2'b01);

        // R9: same-cycle tie goes to multicarrier
        restart(4, 2);
        fork
            begin for (int s = 0; s < 4; s++) send_sym(1, 20); idle(8); end
            poke_on_hit(1'b1, 1'b0);
        join
        chk("R9 tie resolved to multicarrier", mode_flag, 2'b10);

        // R10: clear coincident with a decision drops it
        restart(4, 2);
        fork
            begin for (int s = 0; s < 4; s++) send_sym(1, 20); idle(8); end
            poke_on_hit(1'b0, 1'b1);
        join
        chk("R10 clear beats decision", mode_flag, 2'b00);

        // R11: invalid cycles with garbage data are ignored
        restart(4, 2);
        for (int s = 0; s < 4; s++)
            for (int j = 0; j < 11; j++) begin
                send(20 * bk[j]);
                idle(2);
            end
        idle(6);
        chk("R11 idle strobes ignored", mode_flag, 2'b01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule